// File: doc/BRIEF.md
# Miss Tracking Entry with Deferred Target Queue

This block holds the state of one outstanding cache miss. It records which block is missing, whether the memory request has been sent, and whether that request asks for write permission. Requests that hit the same block wait in the entry as targets until the fill returns. Most join the request already in flight. Some cannot be satisfied by that request: a write arriving after a read-only request went out, or any CPU access after a snoop has claimed the block. These go to a second queue and wait for a follow-up request.

Snoops seen while the request is in flight are handled in one of three ways. If ownership is pending, the snoop is kept and marked so that the cache itself supplies the data. If the snoop takes the block away, it is kept and a pending-invalidate flag is set. Otherwise it is discarded. When the fill arrives, the primary targets leave one per cycle, in order. If deferred targets remain, they become the primary targets and the entry asks for a re-issue with the permission they need, so the entry is not freed.

Top module: `miss_entry`

## Requirements
- R1: After reset the entry is not valid, not in service, not blocked, and drives no response and no re-issue request.
- R2: While the entry is not in service, every accepted CPU target joins the primary queue, and a target with `cpuExcl` set raises `needExcl`. The first CPU target makes the entry valid and captures `cpuAddr` on `entryAddr`.
- R3: While the entry is in service, a CPU target is deferred if any of these holds: the deferred queue is not empty, a pending invalidate is set, or `needExcl` is low and the target asks for exclusive access. Otherwise it joins the primary queue.
- R4: A deferred target with `cpuExcl` set makes the later re-issue request carry `reissueExcl` = 1. A re-issue caused only by read targets carries 0.
- R5: A snoop is accepted only while in service and is dropped once a pending invalidate is set. When `needExcl` is high, the snoop is queued and comes out with `respInhibit` = 1.
- R6: When `needExcl` is low, a snoop with `snpExcl` set is queued with `respInhibit` = 0 and sets pending invalidate. A snoop without `snpExcl` is dropped and never produces a response.
- R7: `fillValid` while in service starts a drain. From the next cycle on, one primary target per cycle appears on the response outputs, in arrival order. `respSnoop` is 1 for snoop targets and 0 for CPU targets.
- R8: For a CPU response, `respOffset` equals the target's block offset minus the offset of the first target of that drain, modulo the block size (2^BLK_OFF_W = 64). Snoop responses carry offset 0.
- R9: In the cycle after the last primary response, if deferred targets exist, `reissueValid` pulses for one cycle. The deferred targets become the primary targets. `inService` drops, `needExcl` takes the deferred-exclusive value, and pending invalidate clears.
- R10: `blocked` is high while the total target count across both queues equals TGT_LIMIT. While it is high, new CPU and snoop targets are ignored.
- R11: `dealloc` is honoured only when both queues are empty and no drain is running. It clears `entryValid`, `inService` and `needExcl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU-side target request |
| cpuAddr | input | ADDR_W | Block address, captured by the first target |
| cpuId | input | TGT_ID_W | Tag of the CPU target |
| cpuOffset | input | BLK_OFF_W | Byte offset of the access inside the block |
| cpuExcl | input | 1 | Target needs write permission |
| issueAck | input | 1 | The memory request for this entry has been sent |
| snpValid | input | 1 | Snoop target request |
| snpId | input | TGT_ID_W | Tag of the snoop |
| snpExcl | input | 1 | Snoop takes the block away (invalidating) |
| fillValid | input | 1 | Fill response has arrived |
| dealloc | input | 1 | Free the entry |
| entryValid | output | 1 | Entry holds a miss |
| entryAddr | output | ADDR_W | Block address of the miss |
| inService | output | 1 | Request is in flight |
| needExcl | output | 1 | Request in flight (or to issue) asks for write permission |
| respValid | output | 1 | A target is being served this cycle |
| respSnoop | output | 1 | Served target is a snoop |
| respInhibit | output | 1 | Served snoop must be answered by this cache |
| respId | output | TGT_ID_W | Tag of the served target |
| respOffset | output | BLK_OFF_W | Transfer offset of the served CPU target |
| reissueValid | output | 1 | Entry must be re-issued to memory |
| reissueExcl | output | 1 | Re-issue must ask for write permission |
| blocked | output | 1 | Target limit reached; cache must stop new accesses |

## Verification
One scenario is repeated with the first target's offset swept over several values. Later offsets land both above and below that first offset, so this shows whether the wrap of the transfer offset is right, and with four targets it also reaches the target limit. A second pattern starts with a read-only request and adds a write, a read, then three snoops. This shows whether the deferred queue stays ordered behind its first entry, which snoops are dropped, and whether the re-issue asks for write permission. A third pattern has a snoop set pending invalidate ahead of a plain read. This shows the deferral caused by the invalidate alone, where the re-issue asks for read permission only.

// File: rtl/miss_entry_pkg.sv
package miss_entry_pkg;
  localparam int TGT_ID_W  = 4;
  localparam int BLK_OFF_W = 6;

  typedef struct packed {
    logic                 isSnoop;
    logic                 inhibit;
    logic [TGT_ID_W-1:0]  id;
    logic [BLK_OFF_W-1:0] offset;
  } target_t;

  localparam int TARGET_W = $bits(target_t);

  typedef struct packed {
    logic    pushPrim;
    logic    pushDef;
    logic    pop;
    logic    swap;
    target_t entry;
  } strobe_t;
endpackage

// File: rtl/miss_entry_fifo.sv
module miss_entry_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= din;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign dout  = mem[rdPtr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full); // R10
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty); // R7
endmodule

// File: rtl/miss_entry_dp.sv
module miss_entry_dp
  import miss_entry_pkg::*;
#(
  parameter int QDEPTH    = 4,
  parameter int TGT_LIMIT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output target_t head,
  output logic    primEmpty,
  output logic    defEmpty,
  output logic    blocked
);
  localparam int CNT_W = $clog2(TGT_LIMIT + 1);

  logic             primSel;
  logic [CNT_W-1:0] tgtCnt;
  logic             qPush  [2];
  logic             qPop   [2];
  logic             qEmpty [2];
  logic             qFull  [2];
  logic [TARGET_W-1:0] qHead [2];

  for (genvar g = 0; g < 2; g++) begin : gQueue
    assign qPush[g] = (primSel == 1'(g)) ? stb.pushPrim : stb.pushDef;
    assign qPop[g]  = (primSel == 1'(g)) && stb.pop;
    miss_entry_fifo #(.DEPTH(QDEPTH), .W(TARGET_W)) u_fifo (
      .clk  (clk),
      .rstN (rstN),
      .push (qPush[g]),
      .pop  (qPop[g]),
      .din  (stb.entry),
      .dout (qHead[g]),
      .empty(qEmpty[g]),
      .full (qFull[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primSel <= 1'b0;
      tgtCnt  <= '0;
    end else begin
      if (stb.swap) primSel <= ~primSel;
      tgtCnt <= tgtCnt + CNT_W'(stb.pushPrim) + CNT_W'(stb.pushDef) - CNT_W'(stb.pop);
    end
  end

  assign head      = target_t'(qHead[primSel]);
  assign primEmpty = qEmpty[primSel];
  assign defEmpty  = qEmpty[~primSel];
  assign blocked   = (tgtCnt == CNT_W'(TGT_LIMIT));

  AST_NO_PUSH_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushPrim || stb.pushDef) |-> !blocked); // R10
  AST_SWAP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.swap |-> (primEmpty && !defEmpty)); // R9
  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.pushPrim && stb.pushDef)); // R3
endmodule

// File: rtl/miss_entry_ctrl.sv
module miss_entry_ctrl
  import miss_entry_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuValid,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [TGT_ID_W-1:0]  cpuId,
  input  logic [BLK_OFF_W-1:0] cpuOffset,
  input  logic                 cpuExcl,
  input  logic                 issueAck,
  input  logic                 snpValid,
  input  logic [TGT_ID_W-1:0]  snpId,
  input  logic                 snpExcl,
  input  logic                 fillValid,
  input  logic                 dealloc,
  input  target_t              head,
  input  logic                 primEmpty,
  input  logic                 defEmpty,
  input  logic                 blocked,
  output strobe_t              stb,
  output logic                 entryValid,
  output logic [ADDR_W-1:0]    entryAddr,
  output logic                 inService,
  output logic                 needExcl,
  output logic                 respValid,
  output logic                 respSnoop,
  output logic                 respInhibit,
  output logic [TGT_ID_W-1:0]  respId,
  output logic [BLK_OFF_W-1:0] respOffset,
  output logic                 reissueValid,
  output logic                 reissueExcl
);
  logic                 defExcl, pendInv, draining;
  logic [BLK_OFF_W-1:0] firstOff;
  logic cpuGo, toDef, snpGo, fillGo, drainEnd, promote, deallocGo, issueGo;

  always_comb begin
    cpuGo     = cpuValid && !dealloc && !blocked && !draining;
    toDef     = inService && (!defEmpty || pendInv || (!needExcl && cpuExcl));
    snpGo     = snpValid && !cpuValid && !dealloc && inService && !draining &&
                !blocked && !pendInv && (needExcl || snpExcl);
    fillGo    = fillValid && inService && !draining && !primEmpty;
    drainEnd  = draining && primEmpty;
    promote   = drainEnd && !defEmpty;
    deallocGo = dealloc && entryValid && !draining && primEmpty && defEmpty;
    issueGo   = issueAck && entryValid && !inService && !draining;

    stb.pushPrim = (cpuGo && !toDef) || snpGo;
    stb.pushDef  = cpuGo && toDef;
    stb.pop      = draining && !primEmpty;
    stb.swap     = promote;
    if (cpuGo) stb.entry = '{isSnoop: 1'b0, inhibit: 1'b0, id: cpuId, offset: cpuOffset};
    else       stb.entry = '{isSnoop: 1'b1, inhibit: needExcl, id: snpId, offset: '0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid <= 1'b0;
      entryAddr  <= '0;
      inService  <= 1'b0;
      needExcl   <= 1'b0;
      defExcl    <= 1'b0;
      pendInv    <= 1'b0;
      draining   <= 1'b0;
      firstOff   <= '0;
    end else if (deallocGo) begin
      entryValid <= 1'b0;
      inService  <= 1'b0;
      needExcl   <= 1'b0;
      defExcl    <= 1'b0;
      pendInv    <= 1'b0;
    end else begin
      if (cpuGo && !entryValid) begin
        entryValid <= 1'b1;
        entryAddr  <= cpuAddr;
      end
      if (cpuGo && !inService && cpuExcl) needExcl <= 1'b1;
      if (cpuGo && toDef && cpuExcl)      defExcl  <= 1'b1;
      if (snpGo && !needExcl)             pendInv  <= 1'b1;
      if (issueGo) inService <= 1'b1;
      if (fillGo) begin
        draining <= 1'b1;
        firstOff <= head.offset;
      end
      if (drainEnd) draining <= 1'b0;
      if (promote) begin
        inService <= 1'b0;
        needExcl  <= defExcl;
        defExcl   <= 1'b0;
        pendInv   <= 1'b0;
      end
    end
  end

  assign respValid    = stb.pop;
  assign respSnoop    = head.isSnoop;
  assign respInhibit  = head.inhibit;
  assign respId       = head.id;
  assign respOffset   = head.isSnoop ? '0 : head.offset - firstOff;
  assign reissueValid = promote;
  assign reissueExcl  = defExcl;

  AST_SNOOP_IN_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushPrim && stb.entry.isSnoop) |-> inService); // R5
  AST_RESP_IN_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> inService); // R7
  AST_REISSUE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    reissueValid |=> (!inService && !reissueValid && entryValid)); // R9
  AST_DEALLOC_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(entryValid) |-> (primEmpty && defEmpty && !inService)); // R11
endmodule

// File: rtl/miss_entry.sv
module miss_entry
  import miss_entry_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int QDEPTH    = 4,
  parameter int TGT_LIMIT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuValid,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [TGT_ID_W-1:0]  cpuId,
  input  logic [BLK_OFF_W-1:0] cpuOffset,
  input  logic                 cpuExcl,
  input  logic                 issueAck,
  input  logic                 snpValid,
  input  logic [TGT_ID_W-1:0]  snpId,
  input  logic                 snpExcl,
  input  logic                 fillValid,
  input  logic                 dealloc,
  output logic                 entryValid,
  output logic [ADDR_W-1:0]    entryAddr,
  output logic                 inService,
  output logic                 needExcl,
  output logic                 respValid,
  output logic                 respSnoop,
  output logic                 respInhibit,
  output logic [TGT_ID_W-1:0]  respId,
  output logic [BLK_OFF_W-1:0] respOffset,
  output logic                 reissueValid,
  output logic                 reissueExcl,
  output logic                 blocked
);
  strobe_t stb;
  target_t head;
  logic    primEmpty, defEmpty;

  miss_entry_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuAddr(cpuAddr), .cpuId(cpuId), .cpuOffset(cpuOffset),
    .cpuExcl(cpuExcl), .issueAck(issueAck), .snpValid(snpValid), .snpId(snpId),
    .snpExcl(snpExcl), .fillValid(fillValid), .dealloc(dealloc),
    .head(head), .primEmpty(primEmpty), .defEmpty(defEmpty), .blocked(blocked),
    .stb(stb), .entryValid(entryValid), .entryAddr(entryAddr),
    .inService(inService), .needExcl(needExcl), .respValid(respValid),
    .respSnoop(respSnoop), .respInhibit(respInhibit), .respId(respId),
    .respOffset(respOffset), .reissueValid(reissueValid), .reissueExcl(reissueExcl)
  );

  miss_entry_dp #(.QDEPTH(QDEPTH), .TGT_LIMIT(TGT_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .head(head),
    .primEmpty(primEmpty), .defEmpty(defEmpty), .blocked(blocked)
  );
endmodule

// File: tb/miss_entry_bench.sv
module miss_entry_bench;
  localparam int ADDR_W = 26;
  localparam int BLK    = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuValid = 0, cpuExcl = 0, issueAck = 0, snpValid = 0, snpExcl = 0;
  logic        fillValid = 0, dealloc = 0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [3:0]  cpuId = '0, snpId = '0;
  logic [5:0]  cpuOffset = '0;
  logic        entryValid, inService, needExcl, respValid, respSnoop, respInhibit;
  logic        reissueValid, reissueExcl, blocked;
  logic [ADDR_W-1:0] entryAddr;
  logic [3:0]  respId;
  logic [5:0]  respOffset;

  int checks = 0, fails = 0;
  int eId [8], eSnp [8], eInh [8], eOff [8];

  always #4 clk = ~clk;

  miss_entry u_miss_entry (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cpu(input int id, input int off, input bit ex, input int addr);
    cpuValid = 1; cpuId = 4'(id); cpuOffset = 6'(off); cpuExcl = ex; cpuAddr = ADDR_W'(addr);
    @(negedge clk);
    cpuValid = 0; cpuExcl = 0;
  endtask

  task automatic snp(input int id, input bit ex);
    snpValid = 1; snpId = 4'(id); snpExcl = ex;
    @(negedge clk);
    snpValid = 0; snpExcl = 0;
  endtask

  task automatic pulseIssue();
    issueAck = 1; @(negedge clk); issueAck = 0;
  endtask

  task automatic pulseDealloc();
    dealloc = 1; @(negedge clk); dealloc = 0;
    chk(entryValid == 0 && inService == 0 && needExcl == 0, "R11", int'(entryValid), 0);
  endtask

  task automatic setExp(input int i, input int id, input int s, input int inh, input int off);
    eId[i] = id; eSnp[i] = s; eInh[i] = inh; eOff[i] = off;
  endtask

  // fill, then compare n responses; then check the re-issue decision
  task automatic drain(input int n, input bit expRe, input bit expReEx);
    fillValid = 1; @(negedge clk); fillValid = 0;
    for (int i = 0; i < n; i++) begin
      int d;
      d = eSnp[i] ? 0 : eOff[i] - eOff[0];
      if (d < 0) d += BLK;
      chk(respValid == 1, "R7 valid", int'(respValid), 1);
      chk(respId == 4'(eId[i]), "R7 order", int'(respId), eId[i]);
      chk(respSnoop == eSnp[i][0], "R7 tag", int'(respSnoop), eSnp[i]);
      if (eSnp[i] != 0) chk(respInhibit == eInh[i][0], "R5/R6 inhibit", int'(respInhibit), eInh[i]);
      chk(int'(respOffset) == d, "R8 offset", int'(respOffset), d);
      @(negedge clk);
    end
    chk(respValid == 0, "R7 end", int'(respValid), 0);
    chk(reissueValid == expRe, "R9 reissue", int'(reissueValid), int'(expRe));
    if (expRe) chk(reissueExcl == expReEx, "R4 reissueExcl", int'(reissueExcl), int'(expReEx));
    @(negedge clk);
    if (expRe) begin
      chk(inService == 0, "R9 inService", int'(inService), 0);
      chk(needExcl == expReEx, "R9 needExcl", int'(needExcl), int'(expReEx));
      chk(reissueValid == 0, "R9 pulse", int'(reissueValid), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(entryValid == 0 && inService == 0 && blocked == 0, "R1 idle", int'(entryValid), 0);
    chk(respValid == 0 && reissueValid == 0, "R1 outputs", int'(respValid), 0);

    // Pattern A: offset sweep, limit reached, ownership-pending snoop
    for (int f = 0; f < BLK; f += 21) begin
      cpu(1, f, 0, 1000 + f);
      chk(entryValid == 1 && entryAddr == ADDR_W'(1000 + f), "R2 addr", int'(entryAddr), 1000 + f);
      chk(needExcl == 0, "R2 read", int'(needExcl), 0);
      cpu(2, 40, 1, 0);
      chk(needExcl == 1, "R2 excl", int'(needExcl), 1);
      pulseIssue();
      chk(inService == 1, "R2 issue", int'(inService), 1);
      cpu(3, 5, 1, 0);   // R3: exclusive already pending -> primary
      snp(9, 0);         // R5: queued with inhibit
      chk(blocked == 1, "R10 blocked", int'(blocked), 1);
      cpu(4, 7, 0, 0);   // R10: ignored
      setExp(0, 1, 0, 0, f); setExp(1, 2, 0, 0, 40);
      setExp(2, 3, 0, 0, 5); setExp(3, 9, 1, 1, 0);
      drain(4, 0, 0);
      chk(blocked == 0, "R10 release", int'(blocked), 0);
      pulseDealloc();
    end

    // Pattern B: read in flight, write deferred, ordering behind it, snoop filtering
    cpu(1, 10, 0, 77);
    pulseIssue();
    cpu(2, 30, 1, 0);   // R3 deferred (needs exclusive)
    cpu(3, 2, 0, 0);    // R3 deferred (deferred queue non-empty)
    snp(5, 0);          // R6 dropped
    snp(6, 1);          // R6 pending invalidate
    dealloc = 1; @(negedge clk); dealloc = 0;
    chk(entryValid == 1, "R11 refused", int'(entryValid), 1);
    snp(7, 1);          // R5 dropped (blocked / pending invalidate)
    setExp(0, 1, 0, 0, 10); setExp(1, 6, 1, 0, 0);
    drain(2, 1, 1);
    pulseIssue();
    setExp(0, 2, 0, 0, 30); setExp(1, 3, 0, 0, 2);
    drain(2, 0, 0);
    pulseDealloc();

    // Pattern C: pending invalidate alone defers a read
    cpu(1, 0, 0, 5);
    pulseIssue();
    snp(4, 1);
    cpu(2, 8, 0, 0);    // R3 deferred by pending invalidate
    snp(8, 1);          // R5 dropped, pending invalidate already set
    setExp(0, 1, 0, 0, 0); setExp(1, 4, 1, 0, 0);
    drain(2, 1, 0);
    pulseIssue();
    setExp(0, 2, 0, 0, 8);
    drain(1, 0, 0);
    pulseDealloc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule